// File: doc/BRIEF.md
# Cascadable Presettable Down-Counter Divider

This block divides its input clock by a programmable whole number N. It is built from a row of identical 4-bit down-counting digits. Each digit raises its own zero flag only when its count is zero and every more significant digit also reports zero. The zero flag of each digit feeds the chain input of the next less significant digit. The flag of the least significant digit is the chain's terminal-count pulse, named the tick. The tick drives the preset-enable input of every digit, so all digits reload their slice of N together and a new count cycle starts without any outside help.

The reload cycle also counts as the first step of the new period. This gives exactly one tick every N input clocks, and for N = 1 the tick stays high on every cycle. A held inhibit input freezes counting. N = 0 parks the chain at zero with the tick held high. Reset is synchronous and active low. It clears every digit, which makes the whole chain read zero and the tick high.

Top module: `dcnt_divider`

## Requirements
- R1: A clock edge with `rst_n` low sets `count` to 0. From the next sample, `tick` and every bit of `digit_zero` are 1.
- R2: `tick` is 1 exactly when the whole `count` equals 0.
- R3: Bit k of `digit_zero` is 1 exactly when digit k (bits 4k+3..4k of `count`) and every more significant digit are zero. The most significant digit's chain input is fixed at 1.
- R4: On an edge where `tick` is 1, `inhibit` is 0 and `div_n` is nonzero, `count` becomes `div_n` - 1.
- R5: On an edge where `tick` is 0 and `inhibit` is 0, `count` decreases by exactly one, with borrows passing between digits.
- R6: On an edge where `tick` is 0 and `inhibit` is 1, `count` keeps its value.
- R7: On an edge where `tick` is 1 and `inhibit` is 1, `count` loads `div_n` unchanged.
- R8: With `div_n` = 0, `count` stays 0 and `tick` stays 1 on every cycle.
- R9: With `inhibit` low and a constant N of 1 or more, rising `tick` samples are exactly N clocks apart. N = 1 keeps `tick` high continuously.
- R10: On a reload, every digit takes its slice of the new value on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| div_n | input | STAGES*DIGIT_W (12) | Division ratio N |
| inhibit | input | 1 | High freezes counting; a reload then takes N unchanged |
| count | output | STAGES*DIGIT_W (12) | Current count of all digits |
| tick | output | 1 | Terminal-count pulse; also the reload enable of every digit |
| digit_zero | output | STAGES (3) | Per-digit zero flag, each qualified by all more significant digits |

## Verification
A wrong digit value shows on `count` at the next sample after the faulty edge. It also changes the period, which moves the next `tick` by one or more clocks. A broken chain or borrow path mostly appears only when a digit wraps or when N has zero slices. For this reason the directed cases include N = 1, N = 15, N = 0, N values with zero low digits, and N = 1 across all three digits, where the zero indication has to pass from the top digit to the bottom. A cycle-exact model compares every output on every clock, so any mismatch is reported in the cycle it happens.

// File: rtl/dcnt_pkg.sv
// Package: shared defaults for the cascadable divider.
// Assumes: all digits have the same width; the chain is at least one digit long.
package dcnt_pkg;
    localparam int unsigned DEF_DIGIT_W = 4;
    localparam int unsigned DEF_STAGES  = 3;
endpackage

// File: rtl/dcnt_digit.sv
// Module: one down-counting digit of the divider chain.
// Loads its preset slice when load_en is high (minus one unless hold is high),
// otherwise decrements unless hold is high. zero_out is qualified by chain_in.
// Assumes: hold already folds in the borrow condition from lower digits.
module dcnt_digit #(
    parameter int unsigned DIGIT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIGIT_W-1:0] preset,
    input  logic               load_en,
    input  logic               hold,
    input  logic               chain_in,
    output logic [DIGIT_W-1:0] cnt,
    output logic               zero_out
);
    localparam logic [DIGIT_W-1:0] ONE = DIGIT_W'(1);

    // Digit state: reset, reload, or borrow-driven decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load_en)
            cnt <= hold ? preset : preset - ONE;
        else if (!hold)
            cnt <= cnt - ONE;
    end

    // Zero flag of this digit, valid only if all upper digits are zero.
    assign zero_out = (cnt == '0) && chain_in;

    // Tracks a reset edge so the clear can be checked on the following edge.
    logic rst_seen;
    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
        if (rst_seen)
            AST_RESET_CLEARS: assert (cnt == '0); // R1
    end

    AST_DIGIT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !hold) |=> cnt == DIGIT_W'($past(cnt) - ONE)); // R5
    AST_DIGIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && hold) |=> $stable(cnt)); // R6
    AST_DIGIT_RAW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && hold) |=> cnt == $past(preset)); // R7
endmodule

// File: rtl/dcnt_hold_gen.sv
// Module: per-digit hold generator.
// A digit may step only if every lower digit is zero: the live count between
// reloads, the incoming preset slices during a reload. The global inhibit, or a
// reload of N = 0, holds every digit.
// Assumes: load is the chain's terminal-count flag.
module dcnt_hold_gen #(
    parameter int unsigned DIGIT_W = 4,
    parameter int unsigned STAGES  = 3
) (
    input  logic                      inhibit,
    input  logic                      load,
    input  logic [STAGES*DIGIT_W-1:0] div_n,
    input  logic [STAGES*DIGIT_W-1:0] count,
    output logic [STAGES-1:0]         hold
);
    logic [STAGES-1:0] lower_nz;
    logic              global_hold;

    // Holds everything under inhibit or on a reload of N = 0.
    assign global_hold = inhibit || (load && (div_n == '0));

    assign lower_nz[0] = 1'b0;
    genvar k;
    generate
        for (k = 1; k < STAGES; k++) begin : g_borrow
            // Any nonzero lower digit (preset during reload) blocks this digit.
            assign lower_nz[k] = lower_nz[k-1] ||
                (load ? (div_n[(k-1)*DIGIT_W +: DIGIT_W] != '0)
                      : (count[(k-1)*DIGIT_W +: DIGIT_W] != '0));
        end
        for (k = 0; k < STAGES; k++) begin : g_hold
            assign hold[k] = global_hold || lower_nz[k];
        end
    endgenerate
endmodule

// File: rtl/dcnt_divider.sv
// Module: top of the cascadable divide-by-N chain.
// Digits are chained most significant to least through their zero flags; the
// least significant flag is the tick and reloads every digit at once.
// Assumes: reset reaches every digit; div_n is steady for a full period when an
// exact ratio is wanted.
module dcnt_divider
    import dcnt_pkg::*;
#(
    parameter int unsigned DIGIT_W = DEF_DIGIT_W,
    parameter int unsigned STAGES  = DEF_STAGES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [STAGES*DIGIT_W-1:0] div_n,
    input  logic                      inhibit,
    output logic [STAGES*DIGIT_W-1:0] count,
    output logic                      tick,
    output logic [STAGES-1:0]         digit_zero
);
    localparam int unsigned TOTAL_W = STAGES * DIGIT_W;

    logic [STAGES-1:0] hold;
    logic [STAGES:0]   chain;

    // The most significant digit sees no digits above it.
    assign chain[STAGES] = 1'b1;

    dcnt_hold_gen #(.DIGIT_W(DIGIT_W), .STAGES(STAGES)) u_hold (
        .inhibit (inhibit),
        .load    (tick),
        .div_n   (div_n),
        .count   (count),
        .hold    (hold)
    );

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_digit
            dcnt_digit #(.DIGIT_W(DIGIT_W)) u_digit (
                .clk      (clk),
                .rst_n    (rst_n),
                .preset   (div_n[k*DIGIT_W +: DIGIT_W]),
                .load_en  (tick),
                .hold     (hold[k]),
                .chain_in (chain[k+1]),
                .cnt      (count[k*DIGIT_W +: DIGIT_W]),
                .zero_out (chain[k])
            );
            if (k + 1 < STAGES) begin : g_chain_chk
                AST_CHAIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
                    digit_zero[k] |-> digit_zero[k+1]); // R3
            end
        end
    endgenerate

    // Terminal count and per-digit flags come straight from the chain.
    assign tick       = chain[0];
    assign digit_zero = chain[STAGES-1:0];

    AST_TICK_MEANS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tick == (count == '0)); // R2
    AST_NZERO_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_n == '0) |=> tick); // R8
    AST_RELOAD_MINUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !inhibit && div_n != '0) |=> count == TOTAL_W'($past(div_n) - 1'b1)); // R4
endmodule

// File: tb/sim_dcnt_divider.sv
`timescale 1ns/1ps
module sim_dcnt_divider;
    localparam int DW = 4;
    localparam int ST = 3;
    localparam int TW = DW * ST;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [TW-1:0] div_n;
    logic          inhibit;
    logic [TW-1:0] count;
    logic          tick;
    logic [ST-1:0] digit_zero;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    logic [TW-1:0] mc = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dcnt_divider u0 (
        .clk(clk), .rst_n(rst_n), .div_n(div_n), .inhibit(inhibit),
        .count(count), .tick(tick), .digit_zero(digit_zero)
    );

    // Next count from the requirements (R1, R4..R8).
    function automatic logic [TW-1:0] model_next(input logic [TW-1:0] c, input logic [TW-1:0] n,
                                                 input logic inh, input logic rn);
        if (!rn) return '0;
        if (c == '0) return (inh || n == '0) ? n : n - 1'b1;
        if (!inh) return c - 1'b1;
        return c;
    endfunction

    // Expected per-digit zero flags (R3).
    function automatic logic [ST-1:0] model_dz(input logic [TW-1:0] c);
        logic [ST-1:0] r;
        logic above = 1'b1;
        for (int k = ST - 1; k >= 0; k--) begin
            above = above && (c[k*DW +: DW] == '0);
            r[k] = above;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare just after.
    task automatic step(input logic rn, input logic [TW-1:0] n, input logic inh);
        string req;
        @(negedge clk);
        rst_n = rn; div_n = n; inhibit = inh;
        if (!rn) req = "R1";
        else if (mc == '0) req = inh ? "R7" : (n == '0 ? "R8" : "R4");
        else req = inh ? "R6" : "R5";
        @(posedge clk);
        mc = model_next(mc, n, inh, rn);
        #1;
        check(req, count, mc);
        check("R2", tick, mc == '0);
        check("R3", digit_zero, model_dz(mc));
    endtask

    // Watchdog: an overrun counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic do_reset(input logic [TW-1:0] n);
        step(1'b0, n, 1'b0);
        step(1'b0, n, 1'b0);
    endtask

    // Measures the tick spacing for a constant N (R9).
    task automatic period_check(input logic [TW-1:0] n);
        int last = -1;
        int seen = 0;
        do_reset(n);
        for (int i = 0; i < 3 * n + 4; i++) begin
            step(1'b1, n, 1'b0);
            if (tick) begin
                if (last >= 0) begin
                    check("R9", i - last, (n == 1) ? 1 : n);
                    seen++;
                end
                last = i;
            end
        end
        check("R9 ticks seen", seen >= 2, 1'b1);
    endtask

    initial begin
        logic [TW-1:0] n;
        logic inh;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; div_n = '0; inhibit = 1'b0;

        // R1 reset state.
        do_reset(12'h321);
        check("R1 tick", tick, 1'b1);
        check("R1 digit_zero", digit_zero, 3'b111);

        // R10: reload takes all digits on one edge.
        step(1'b1, 12'h321, 1'b0);
        check("R10", count, 12'h320);

        // Directed periods, including N=1 rippling through all digits.
        period_check(12'd1);
        period_check(12'd15);
        period_check(12'h010);
        period_check(12'h100);
        period_check(12'd37);

        // R8: N = 0 parks the chain.
        do_reset(12'h000);
        for (int i = 0; i < 20; i++) step(1'b1, 12'h000, i[0]);
        check("R8 parked", count, 12'h000);

        // R7 / R6: reload under inhibit, then frozen count.
        do_reset(12'h00A);
        step(1'b1, 12'h00A, 1'b1);
        check("R7 raw load", count, 12'h00A);
        for (int i = 0; i < 5; i++) step(1'b1, 12'h00A, 1'b1);
        check("R6 frozen", count, 12'h00A);

        // Constrained random mix.
        n = 12'd9;
        for (int i = 0; i < 6000; i++) begin
            if ($urandom % 200 == 0)
                n = ($urandom % 4 == 0) ? 12'($urandom % 4096) : 12'($urandom % 40);
            inh = ($urandom % 5 == 0);
            step(($urandom % 700) != 0, n, inh);
        end

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule